// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a read-only cache for one requester. Its main store is a direct-mapped array of one-word lines. Behind it sits a small fully-associative victim buffer that keeps lines pushed out of the array. The buffer absorbs conflict misses: two addresses that share a set can both stay on chip, one in the array and one in the buffer.

A read is first looked up in the array. If the array misses, the buffer is probed on the next cycle. A buffer hit swaps lines: the requested line goes back into the array, and the array's previous line takes the freed buffer slot. If both miss, the block issues a fetch to the next level. The returned line is installed in the array, and the line it displaces is pushed into the buffer.

Addresses are line addresses. The low index bits select the set and the remaining bits are the tag.

Top module: `victim_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_req_valid is 0, and no line is valid in either store, so the first read of any address goes to the next level.
- R2: A read that hits the array returns resp_valid with the line's data one cycle after the accepting edge, and raises no next-level request.
- R3: On a miss in both stores, mem_req_valid rises two cycles after the accepting edge with mem_req_addr equal to the request address. Both are held until mem_resp_valid is seen.
- R4: At the edge where mem_resp_valid is sampled during a fetch, resp_valid is raised with resp_data equal to mem_resp_data, and the line is installed in the array.
- R5: The buffer is probed only after an array miss. A buffer hit returns data two cycles after the accepting edge, with no next-level request.
- R6: A fetch that replaces a valid array line writes the displaced line into the victim buffer.
- R7: On a buffer hit, the requested line moves into the array and the displaced array line takes the same buffer slot. Afterwards the requested address hits the array, the displaced one hits the buffer, and no address is held in two buffer slots.
- R8: Two addresses that alternate in one set cause no next-level traffic after both have been fetched once.
- R9: Lines pushed in by fetches go to a round-robin slot pointer that starts at slot 0 and advances by one per push. With 4 slots, the fifth push overwrites the slot written by the first push.
- R10: req_ready is 0 from the accepting edge of an array miss until its response. resp_valid is only ever high while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Line address of the read |
| resp_valid | output | 1 | Read data valid (one cycle) |
| resp_data | output | LINE_W | Read data |
| mem_req_valid | output | 1 | Next-level fetch outstanding |
| mem_req_addr | output | ADDR_W | Line address being fetched |
| mem_resp_valid | input | 1 | Next-level line returned |
| mem_resp_data | input | LINE_W | Returned line |

## Verification
An array hit is due one cycle after the accepting edge and a buffer hit two cycles after it. A fetch request is due two cycles after the accepting edge. A fetch response is due at the edge where the next-level data is sampled. The bench accepts each request at a rising edge and samples one nanosecond after every following edge. It counts those edges and compares the count to 1 or 2 for hits. For misses, it checks that nothing is requested at the first sample and that the fetch address is present at the second. A next-level model counts every fetch, so hit and ping-pong cases are also checked for zero traffic.

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ADDR_W   = 16,
  parameter int LINE_W   = 32,
  parameter int SETS     = 8,
  parameter int VB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [LINE_W-1:0] resp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [LINE_W-1:0] mem_resp_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int PTR_W = $clog2(VB_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_FETCH} state_t;
  state_t state;

  logic              m_valid [SETS];
  logic [TAG_W-1:0]  m_tag   [SETS];
  logic [LINE_W-1:0] m_data  [SETS];
  logic              v_valid [VB_DEPTH];
  logic [ADDR_W-1:0] v_addr  [VB_DEPTH];
  logic [LINE_W-1:0] v_data  [VB_DEPTH];
  logic [PTR_W-1:0]  v_ptr;
  logic [ADDR_W-1:0] cur_addr;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              main_hit;
  logic [ADDR_W-1:0] evict_addr;
  logic [VB_DEPTH-1:0] vhit;
  logic [PTR_W-1:0]  vsel;
  logic              accept;

  assign req_ready     = (state == S_IDLE);
  assign accept        = req_valid && req_ready;
  assign lk_addr       = (state == S_IDLE) ? req_addr : cur_addr;
  assign idx           = lk_addr[IDX_W-1:0];
  assign tag           = lk_addr[ADDR_W-1:IDX_W];
  assign main_hit      = m_valid[idx] && (m_tag[idx] == tag);
  assign evict_addr    = {m_tag[idx], idx};
  assign mem_req_valid = (state == S_FETCH);
  assign mem_req_addr  = cur_addr;

  for (genvar i = 0; i < VB_DEPTH; i++) begin : g_vcmp
    assign vhit[i] = v_valid[i] && (v_addr[i] == cur_addr);
  end

  always_comb begin
    vsel = '0;
    for (int i = 0; i < VB_DEPTH; i++)
      if (vhit[i]) vsel = PTR_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      resp_valid <= 1'b0;
      v_ptr      <= '0;
      cur_addr   <= '0;
      for (int s = 0; s < SETS; s++) m_valid[s] <= 1'b0;
      for (int v = 0; v < VB_DEPTH; v++) v_valid[v] <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (accept) begin
            cur_addr <= req_addr;
            if (main_hit) begin
              resp_valid <= 1'b1;
              resp_data  <= m_data[idx];
            end else begin
              state <= S_PROBE;
            end
          end
        S_PROBE:
          if (|vhit) begin
            resp_valid    <= 1'b1;
            resp_data     <= v_data[vsel];
            m_valid[idx]  <= 1'b1;
            m_tag[idx]    <= tag;
            m_data[idx]   <= v_data[vsel];
            v_valid[vsel] <= m_valid[idx];
            v_addr[vsel]  <= evict_addr;
            v_data[vsel]  <= m_data[idx];
            state         <= S_IDLE;
          end else begin
            state <= S_FETCH;
          end
        S_FETCH:
          if (mem_resp_valid) begin
            resp_valid   <= 1'b1;
            resp_data    <= mem_resp_data;
            m_valid[idx] <= 1'b1;
            m_tag[idx]   <= tag;
            m_data[idx]  <= mem_resp_data;
            if (m_valid[idx]) begin
              v_valid[v_ptr] <= 1'b1;
              v_addr[v_ptr]  <= evict_addr;
              v_data[v_ptr]  <= m_data[idx];
              v_ptr <= (v_ptr == PTR_W'(VB_DEPTH - 1)) ? '0 : v_ptr + 1'b1;
            end
            state <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/victim_cache_chk.sv
module victim_cache_chk #(
  parameter int ADDR_W   = 16,
  parameter int VB_DEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_resp_valid,
  input logic [VB_DEPTH-1:0] vhit
);
  assert_fetch_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_addr));

  assert_fill_responds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_resp_valid |=> resp_valid);

  assert_probe_before_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !mem_req_valid);

  assert_single_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vhit));

  assert_resp_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);
endmodule

bind victim_cache victim_cache_chk #(.ADDR_W(ADDR_W), .VB_DEPTH(VB_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_resp_valid(mem_resp_valid), .vhit(vhit)
);

// File: tb/victim_cache_tb_top.sv
module victim_cache_tb_top;
  localparam int AW = 16;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, resp_valid, mem_req_valid;
  logic [LW-1:0] resp_data;
  logic [AW-1:0] mem_req_addr;
  logic mem_resp_valid = 1'b0;
  logic [LW-1:0] mem_resp_data = '0;

  int n_checks = 0;
  int n_fails = 0;
  int mem_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  victim_cache #(.ADDR_W(AW), .LINE_W(LW), .SETS(8), .VB_DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
    return {a ^ 16'hA5A5, a};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // next-level model: answers each fetch two cycles after seeing it
  initial begin
    forever begin
      @(negedge clk);
      mem_resp_valid = 1'b0;
      if (mem_req_valid) begin
        @(negedge clk);
        @(negedge clk);
        mem_resp_data  = line_of(mem_req_addr);
        mem_resp_valid = 1'b1;
        mem_cnt++;
      end
    end
  end

  // kind: 0 array hit, 1 buffer hit, 2 miss in both
  task automatic rd(input logic [AW-1:0] a, input int kind, input string rq);
    int cyc;
    int m0;
    m0 = mem_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    #1 req_valid = 1'b0;
    cyc = 1;
    if (kind == 2) begin
      check(!req_ready, {rq, " R10 busy after miss"}, 64'(req_ready), 0);
      check(!mem_req_valid, {rq, " R3 no fetch at first cycle"}, 64'(mem_req_valid), 0);
    end
    while (!resp_valid && cyc < 100) begin
      @(posedge clk);
      #1 cyc++;
      if (kind == 2 && cyc == 2)
        check(mem_req_valid && mem_req_addr == a, {rq, " R3 fetch address"}, 64'(mem_req_addr), 64'(a));
    end
    check(resp_valid && resp_data == line_of(a), {rq, " data"}, 64'(resp_data), 64'(line_of(a)));
    if (kind < 2)
      check(cyc == kind + 1, {rq, " latency"}, 64'(cyc), 64'(kind + 1));
    check(mem_cnt - m0 == (kind == 2 ? 1 : 0), {rq, " fetch count"}, 64'(mem_cnt - m0), 64'(kind == 2 ? 1 : 0));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !resp_valid && !mem_req_valid, "R1 reset outputs",
          64'({req_ready, resp_valid, mem_req_valid}), 64'(3'b100));
  endtask

  task automatic t_cold_and_hit();
    rd(16'h0010, 2, "R1 R4 cold miss");
    rd(16'h0010, 0, "R2 array hit");
  endtask

  task automatic t_conflict();
    rd(16'h0018, 2, "R6 conflict fetch");
    rd(16'h0010, 1, "R5 R6 buffer hit on evicted line");
    rd(16'h0010, 0, "R7 swapped line now in array");
    rd(16'h0018, 1, "R7 displaced line in buffer");
  endtask

  task automatic t_pingpong();
    int m0;
    m0 = mem_cnt;
    for (int k = 0; k < 3; k++) begin
      rd(16'h0010, 1, "R8 ping");
      rd(16'h0018, 1, "R8 pong");
    end
    rd(16'h0010, 1, "R8 ping last");
    check(mem_cnt == m0, "R8 no traffic", 64'(mem_cnt - m0), 0);
  endtask

  task automatic t_fifo();
    // buffer now: slot0 holds 0x0018, pointer at 1
    rd(16'h0001, 2, "R9 fill set1");
    rd(16'h0009, 2, "R9 push to slot1");
    rd(16'h0011, 2, "R9 push to slot2");
    rd(16'h0019, 2, "R9 push to slot3");
    rd(16'h0021, 2, "R9 push wraps to slot0");
    rd(16'h0009, 1, "R9 slot2 entry kept");
    rd(16'h0018, 2, "R9 oldest slot overwritten");
  endtask

  initial begin
    t_reset();
    t_cold_and_hit();
    t_conflict();
    t_pingpong();
    t_fifo();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule